// File: doc/BRIEF.md
# Serial Peripheral Shift Controller

This block is a register-controlled synchronous serial port that normally drives the bus as its clock master. Software programs a control register, then writes a byte into the data register. The block shifts that byte out and shifts a byte in over eight clock periods, both in the same transfer. It produces the serial clock by dividing the system clock, using a rate code set in the control and status registers. When the transfer ends it latches the received byte, sets a completion flag and, if allowed, raises an interrupt.

The same shift engine also serves as a bus slave. It enters slave mode when the master bit is clear. It also enters slave mode when a configured master finds its slave-select line, strapped as an input, pulled low. In that case the block drops its master bit and reports the change through the completion flag, so software can see that it lost the bus.

Top module: `sspi_ctl`

## Requirements
- R1: Three registers: address 0 is control, with [7] enable, [6] interrupt enable, [5] LSB-first, [4] master, [3] idle-high clock, [2] late sampling and [1:0] rate. Address 1 is status, with [7] done, [6] collision and [0] double speed. Address 2 writes the transmit byte and reads the receive buffer. After reset every register reads 0, and irq and all output enables are low.
- R2: The system-clock division is set by rate and double speed. Rate 0 gives 4 (2 with double speed), rate 1 gives 16 (8), rate 2 gives 64 (32) and rate 3 gives 128 (64). SCK holds its idle level for half a period after the start, then makes exactly 16 transitions, one every half period.
- R3: With LSB-first set, bit 0 goes out first and the first bit received lands in bit 0. Otherwise bit 7 goes out first and the first bit received ends up in bit 7.
- R4: SCK idles at the idle-high bit. With late sampling clear, the first data bit is on MOSI before the first edge, input is sampled on odd-numbered edges and output changes on even-numbered edges. With late sampling set, output changes on edges 3, 5 and so on, and input is sampled on even-numbered edges.
- R5: In master mode, a data write while enabled and idle starts a transfer. The received byte is latched at the 16th edge. Until then, reads of the data register return the previous byte.
- R6: Done is set when a transfer completes. irq is high exactly when enable, interrupt enable and done are all set.
- R7: Done and collision are cleared by a pulse on irq_ack. They are also cleared by a data-register access that follows a status read which returned either flag set.
- R8: A data write during a transfer does not change the byte being shifted out, and it sets collision.
- R9: When an enabled master has ss_as_input high and sees ss_n_i low, it clears its master bit and sets done. With ss_as_input low, ss_n_i is ignored in master mode.
- R10: In slave mode, sck_i and mosi_i are used, miso_oe is high only while ss_n_i is low, and a byte is exchanged over 16 sck_i edges using the same ordering rules.
- R11: Clearing enable returns SCK to its idle level in the next cycle and aborts the transfer without setting done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational on reg_addr |
| irq | output | 1 | Completion interrupt |
| irq_ack | input | 1 | Interrupt service pulse, clears flags |
| ss_as_input | input | 1 | Slave-select pin strapped as input |
| ss_n_i | input | 1 | Slave-select line, active low |
| sck_i | input | 1 | Serial clock in (slave mode) |
| sck_o | output | 1 | Serial clock out (master mode) |
| sck_oe | output | 1 | Serial clock output enable |
| mosi_i | input | 1 | Master-out line in (slave mode) |
| mosi_o | output | 1 | Master-out line out |
| mosi_oe | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line in (master mode) |
| miso_o | output | 1 | Slave-out line out |
| miso_oe | output | 1 | Slave-out output enable |

## Verification
The assertions assume that software does not rewrite the rate or the double-speed bit while a master transfer is running. The gap between clock ticks holds only if the divider stays fixed. They also assume that the slave-mode inputs change no faster than the two-stage synchronizer can follow. The stimulus changes configuration only between transfers. In slave mode it holds every sck_i level for at least six system clocks and sets mosi_i several cycles before the sampling edge. It also raises collision writes only on cycles that fall between clock ticks.

// File: rtl/sspi_pkg.sv
`timescale 1ns/1ps
package sspi_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 7;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam int ST_DONE = 7;
  localparam int ST_COL  = 6;
  localparam int ST_DBL  = 0;

  typedef struct packed {
    logic       en;
    logic       ie;
    logic       lsb_first;
    logic       master;
    logic       idle_hi;
    logic       late;
    logic [1:0] rate;
  } ctrl_t;

  // half of the SCK period in system clocks
  function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate, input logic dbl);
    logic [HALF_W:0] full;
    case (rate)
      2'd0:    full = 8'd4;
      2'd1:    full = 8'd16;
      2'd2:    full = 8'd64;
      default: full = 8'd128;
    endcase
    if (dbl) full = full >> 1;
    return full[HALF_W:1];
  endfunction
endpackage

// File: rtl/sspi_sync.sv
`timescale 1ns/1ps
module sspi_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/sspi_sck_gen.sv
`timescale 1ns/1ps
module sspi_sck_gen
  import sspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || tick)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  // R2: two ticks are a full half period apart unless the half period is one clock
  a_r2_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && half > 1) |=> (!tick || half == 1));
endmodule

// File: rtl/sspi_shift_core.sv
`timescale 1ns/1ps
module sspi_shift_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          abort,
  input  logic          edge_ev,
  input  logic          lsb_first,
  input  logic          late,
  input  logic          serial_in,
  output logic          serial_out,
  output logic          mid,
  output logic          done_pulse,
  output logic [DW-1:0] rx_next
);
  localparam int KW = $clog2(2*DW);
  localparam logic [KW-1:0] K_LAST = KW'(2*DW-1);

  logic [KW-1:0] k_q;
  logic [DW-1:0] sh_q, rx_q;
  logic sample_ev, shift_ev;

  assign sample_ev  = edge_ev && (k_q[0] == late);
  assign shift_ev   = edge_ev && (k_q[0] != late) && (k_q != '0);
  assign done_pulse = edge_ev && (k_q == K_LAST);
  assign mid        = (k_q != '0);
  assign serial_out = lsb_first ? sh_q[0] : sh_q[DW-1];

  always_comb begin
    rx_next = rx_q;
    if (sample_ev) begin
      if (lsb_first) rx_next = {serial_in, rx_q[DW-1:1]};
      else           rx_next = {rx_q[DW-2:0], serial_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q  <= '0;
      sh_q <= '0;
      rx_q <= '0;
    end else begin
      rx_q <= rx_next;
      if (load) begin
        sh_q <= load_data;
        k_q  <= '0;
      end else if (abort) begin
        k_q <= '0;
      end else if (edge_ev) begin
        k_q <= done_pulse ? '0 : k_q + 1'b1;
        if (shift_ev) begin
          if (lsb_first) sh_q <= {1'b0, sh_q[DW-1:1]};
          else           sh_q <= {sh_q[DW-2:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/sspi_ctl.sv
`timescale 1ns/1ps
module sspi_ctl
  import sspi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  input  logic              irq_ack,
  input  logic              ss_as_input,
  input  logic              ss_n_i,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe
);
  ctrl_t             ctrl_q;
  logic              dbl_q, done_q, col_q, armed_q, mbusy_q, tog_q, sck_s_d;
  logic [BYTE_W-1:0] rxbuf_q;

  // synchronized pins
  logic [2:0] sync_q;
  logic       ss_s, sck_s, mosi_s;
  sspi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ss_n_i, sck_i, mosi_i}), .q(sync_q));
  assign ss_s   = sync_q[2];
  assign sck_s  = sync_q[1];
  assign mosi_s = sync_q[0];

  // register access decode
  logic ctrl_wr, stat_wr, data_wr, stat_rd, data_rd;
  assign ctrl_wr = reg_wr && reg_addr == A_CTRL;
  assign stat_wr = reg_wr && reg_addr == A_STAT;
  assign data_wr = reg_wr && reg_addr == A_DATA;
  assign stat_rd = reg_rd && reg_addr == A_STAT;
  assign data_rd = reg_rd && reg_addr == A_DATA;

  // mode and event wires
  logic master_mode, slave_mode, core_mid, busy, start, demote;
  logic tick, slave_edge, edge_ev, core_done, core_out, abort, flag_clr;
  logic [BYTE_W-1:0] rx_next;
  logic [HALF_W-1:0] half;

  assign master_mode = ctrl_q.en && ctrl_q.master;
  assign slave_mode  = ctrl_q.en && !ctrl_q.master;
  assign busy        = mbusy_q || (slave_mode && !ss_s && core_mid);
  assign start       = data_wr && ctrl_q.en && !busy;
  assign demote      = master_mode && ss_as_input && !ss_s;
  assign slave_edge  = slave_mode && !ss_s && (sck_s != sck_s_d);
  assign edge_ev     = mbusy_q ? tick : slave_edge;
  assign abort       = !ctrl_q.en || demote || (slave_mode && ss_s);
  assign half        = half_period(ctrl_q.rate, dbl_q);
  assign flag_clr    = irq_ack || (armed_q && (data_wr || data_rd));

  sspi_sck_gen u_sck_gen (
    .clk(clk), .rst_n(rst_n), .run(mbusy_q && master_mode), .half(half), .tick(tick));

  sspi_shift_core #(.DW(BYTE_W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(start), .load_data(reg_wdata), .abort(abort),
    .edge_ev(edge_ev), .lsb_first(ctrl_q.lsb_first), .late(ctrl_q.late),
    .serial_in(master_mode ? miso_i : mosi_s), .serial_out(core_out),
    .mid(core_mid), .done_pulse(core_done), .rx_next(rx_next));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      dbl_q   <= 1'b0;
      done_q  <= 1'b0;
      col_q   <= 1'b0;
      armed_q <= 1'b0;
      mbusy_q <= 1'b0;
      tog_q   <= 1'b0;
      sck_s_d <= 1'b0;
      rxbuf_q <= '0;
    end else begin
      sck_s_d <= sck_s;
      if (ctrl_wr)     ctrl_q        <= ctrl_t'(reg_wdata);
      else if (demote) ctrl_q.master <= 1'b0;
      if (stat_wr) dbl_q <= reg_wdata[ST_DBL];

      if (!ctrl_q.en || demote || core_done) mbusy_q <= 1'b0;
      else if (start && master_mode)         mbusy_q <= 1'b1;

      if (!mbusy_q)  tog_q <= 1'b0;
      else if (tick) tog_q <= ~tog_q;

      if (core_done) rxbuf_q <= rx_next;

      done_q <= (done_q && !flag_clr) || core_done || demote;
      col_q  <= (col_q && !flag_clr) || (data_wr && busy);
      if (flag_clr)                        armed_q <= 1'b0;
      else if (stat_rd && (done_q || col_q)) armed_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_STAT:  reg_rdata = {done_q, col_q, 5'b0, dbl_q};
      A_DATA:  reg_rdata = rxbuf_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq     = ctrl_q.en && ctrl_q.ie && done_q;
  assign sck_o   = ctrl_q.idle_hi ^ (tog_q && mbusy_q && master_mode);
  assign sck_oe  = master_mode;
  assign mosi_o  = core_out;
  assign mosi_oe = master_mode;
  assign miso_o  = core_out;
  assign miso_oe = slave_mode && !ss_s;

  // R6: done only rises after a completed byte or a mode loss
  a_r6_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(core_done || demote));
  // R8: a colliding write leaves the outgoing bit untouched
  a_r8_collision_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && mbusy_q && !tick && !ctrl_wr) |=> $stable(mosi_o));
  // R9: mode loss clears the master bit
  a_r9_demote_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (demote && !ctrl_wr) |=> !ctrl_q.master);
  // R11: disabling ends a master transfer
  a_r11_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |=> !mbusy_q);
  // R4: after the last edge SCK is back at its idle level
  a_r4_sck_returns_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (core_done && mbusy_q && !ctrl_wr) |=> (sck_o == ctrl_q.idle_hi));
endmodule

// File: tb/sspi_ctl_bench.sv
`timescale 1ns/1ps
module sspi_ctl_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] reg_addr;
  logic reg_wr, reg_rd, irq, irq_ack, ss_as_input, ss_n_i;
  logic [7:0] reg_wdata, reg_rdata;
  logic sck_i, sck_o, sck_oe, mosi_i, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;

  int nvec = 0;
  int nfail = 0;
  logic [7:0] prev_rx = 8'h00;
  logic [7:0] pat = 8'h5B;
  int div_tab [8] = '{4, 2, 16, 8, 64, 32, 128, 64};

  always #2.5 clk = ~clk;

  sspi_ctl u_sspi_ctl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .irq_ack(irq_ack),
    .ss_as_input(ss_as_input), .ss_n_i(ss_n_i), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural master transfer model, compared on every clock
  task automatic xfer(input logic [7:0] ctrlv, input logic dbl, input logic [7:0] data,
                      input int col_at, input bit use_ack);
    int half, t, nsh;
    logic [7:0] exp_rx, v;
    logic idle, lsb, late, ie;
    half = div_tab[ctrlv[1:0]*2 + int'(dbl)] / 2;
    idle = ctrlv[3]; lsb = ctrlv[5]; late = ctrlv[2]; ie = ctrlv[6];
    wr(2'd0, ctrlv);
    wr(2'd1, {7'b0, dbl});
    reg_addr = 2'd2; reg_wdata = data; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    exp_rx = 8'h00;
    for (int j = 0; j < 16*half; j++) begin
      t = j / half;
      nsh = late ? ((t == 0) ? 0 : (t - 1) / 2) : t / 2;
      if (nsh > 7) nsh = 7;
      check("R2/R4 sck level", sck_o, idle ^ t[0]);
      check("R3/R4 mosi bit", mosi_o, lsb ? data[nsh] : data[7-nsh]);
      check("R6 irq low during transfer", irq, 1'b0);
      check("R5 old byte readable", reg_rdata, prev_rx);
      if (j == col_at) begin reg_wr = 1'b1; reg_wdata = ~data; end
      else reg_wr = 1'b0;
      miso_i = pat[0];
      pat = {pat[6:0], pat[7] ^ pat[5] ^ pat[4] ^ pat[3]};
      if ((j + 1) % half == 0 && ((j / half) % 2) == int'(!late ? 1'b0 : 1'b1))
        exp_rx = lsb ? {miso_i, exp_rx[7:1]} : {exp_rx[6:0], miso_i};
      @(negedge clk);
    end
    reg_wr = 1'b0;
    check("R6 irq at completion", irq, ie);
    check("R4 sck idle after", sck_o, idle);
    rd(2'd2, v); check("R5 received byte", v, exp_rx);
    prev_rx = exp_rx;
    if (use_ack) begin
      irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
      check("R7 irq cleared by ack", irq, 1'b0);
      rd(2'd1, v); check("R7 done cleared by ack", v[7], 1'b0);
    end else begin
      rd(2'd1, v);
      check("R6 done set", v[7], 1'b1);
      check("R8 collision flag", v[6], col_at >= 0);
      rd(2'd2, v);
      check("R7 irq cleared by access", irq, 1'b0);
      rd(2'd1, v); check("R7 flags cleared", v[7:6], 2'b00);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = 8'h00;
    irq_ack = 1'b0; ss_as_input = 1'b0; ss_n_i = 1'b1; sck_i = 1'b0; mosi_i = 1'b0; miso_i = 1'b0;
    wait_n(4);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); check("R1 control reset", v, 8'h00);
    rd(2'd1, v); check("R1 status reset", v, 8'h00);
    rd(2'd2, v); check("R1 data reset", v, 8'h00);
    check("R1 irq reset", irq, 1'b0);
    check("R1 sck_oe reset", sck_oe, 1'b0);
    check("R1 mosi_oe reset", mosi_oe, 1'b0);
    check("R1 miso_oe reset", miso_oe, 1'b0);

    // master transfers across divider codes, orders and clock modes
    xfer(8'hD0, 1'b0, 8'hA5, -1, 1'b0);   // R2 /4, msb first, early sample
    xfer(8'hFD, 1'b1, 8'h3C, -1, 1'b0);   // R2 /8, R3 lsb first, R4 idle high, late
    xfer(8'hD8, 1'b1, 8'h81, -1, 1'b1);   // R2 /2, R7 ack clear
    xfer(8'hD6, 1'b0, 8'h5A,  5, 1'b0);   // R2 /64, R8 collision
    xfer(8'hF3, 1'b0, 8'hC3, -1, 1'b0);   // R2 /128
    xfer(8'h91, 1'b0, 8'h7E, -1, 1'b0);   // R2 /16, R6 irq gated off
    xfer(8'hD2, 1'b1, 8'h96, -1, 1'b0);   // R2 /32
    xfer(8'hDF, 1'b1, 8'h1E, -1, 1'b0);   // R2 /64 via code 3 with double speed

    // R11 disable mid-transfer
    wr(2'd0, 8'h92); wr(2'd1, 8'h00);
    wr(2'd2, 8'hF0);
    wait_n(40);
    check("R11 sck toggled before disable", sck_o, 1'b1);
    wr(2'd0, 8'h00);
    check("R11 sck idle after disable", sck_o, 1'b0);
    check("R11 sck_oe off", sck_oe, 1'b0);
    for (int i = 0; i < 100; i++) begin
      if (sck_o !== 1'b0) check("R11 sck stays idle", sck_o, 1'b0);
      @(negedge clk);
    end
    rd(2'd1, v); check("R11 no done on abort", v[7], 1'b0);

    // R9 slave-select ignored when not strapped as input
    wr(2'd0, 8'hD0);
    ss_n_i = 1'b0;
    wait_n(6);
    rd(2'd0, v); check("R9 master kept", v[4], 1'b1);
    rd(2'd1, v); check("R9 no done", v[7], 1'b0);
    ss_as_input = 1'b1;
    wait_n(6);
    rd(2'd0, v); check("R9 master cleared", v, 8'hC0);
    check("R9 irq on mode loss", irq, 1'b1);
    rd(2'd1, v); check("R9 done on mode loss", v[7], 1'b1);
    rd(2'd2, v);
    ss_n_i = 1'b1; ss_as_input = 1'b0;
    wait_n(4);

    // R10 slave exchange, msb first, early sample
    wr(2'd0, 8'h80);
    check("R10 miso quiet while deselected", miso_oe, 1'b0);
    wr(2'd2, 8'h3C);
    ss_n_i = 1'b0;
    wait_n(4);
    check("R10 miso driven when selected", miso_oe, 1'b1);
    for (int i = 0; i < 8; i++) begin
      logic [7:0] tx = 8'h3C;
      logic [7:0] rx = 8'h96;
      check("R10 slave out bit", miso_o, tx[7-i]);
      mosi_i = rx[7-i];
      wait_n(4);
      sck_i = 1'b1;
      wait_n(6);
      sck_i = 1'b0;
      wait_n(6);
    end
    check("R6 slave irq gated", irq, 1'b0);
    ss_n_i = 1'b1;
    wait_n(4);
    check("R10 miso released", miso_oe, 1'b0);
    rd(2'd2, v); check("R10 slave received byte", v, 8'h96);
    rd(2'd1, v); check("R10 slave done", v[7], 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule